// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block produces the address of one memory operand for a 16-bit processor that uses segmented memory. A caller presents a mode (zero or one base register, zero or one index register, an optional displacement), the current base, index and segment register values, an optional segment override, and a request strobe. The block returns the 16-bit offset (effective address), a code for the segment it used, and the 20-bit physical address.

The offset is the 16-bit sum of the chosen terms, and any carry out of the top bit is dropped. The physical address is the segment value shifted left by four bits plus the offset, truncated to 20 bits. A mode with more terms takes more cycles: one cycle for one term, two for two, three for three. Operands are captured when the request is taken, so the caller may change them right afterwards. Modes with no term, or with a register code that is not allowed, are rejected with a one-cycle illegal flag and no result.

Top module: `seg_ea_gen`

## Requirements
- R1: Every mode made of at most one base (BX code 1, BP code 2), at most one index (SI code 1, DI code 2) and at most one displacement, with at least one term, is legal and yields a result. These 17 modes have no other legal members.
- R2: A request with no term, or with base code 3 or index code 3, raises `illegal_o` for exactly one cycle, in the cycle after the request, and `valid_o` stays low for it.
- R3: With no override, a mode that uses BP selects the stack segment (`seg_o` = 2). Every other mode selects the data segment (`seg_o` = 3).
- R4: With `ovr_en_i` high, `ovr_sel_i` picks the segment directly: 0 = ES, 1 = CS, 2 = SS, 3 = DS. `seg_o` reports the same code.
- R5: In displacement-only mode all 16 bits of `disp_i` are an unsigned offset, whatever `disp_wide_i` says.
- R6: In any other mode with a displacement, `disp_wide_i` = 1 uses all 16 bits of `disp_i`. `disp_wide_i` = 0 sign-extends `disp_i[7:0]`, and the upper byte has no effect.
- R7: The effective address is the sum of the terms modulo 2^16 (BX=0010h with displacement FFFFh gives 000Fh).
- R8: If a request is taken in cycle c with N terms, `valid_o` is high only in cycle c+N, for exactly one cycle.
- R9: When `valid_o` is high, `pa_o` equals (segment value * 16 + `ea_o`) modulo 2^20.
- R10: Register, segment, displacement and mode inputs are sampled in the request cycle. Changes to them afterwards do not change the result.
- R11: A request that arrives while a calculation is in progress is ignored. It produces no result and no illegal flag.
- R12: After reset, `valid_o` and `illegal_o` are low and `ea_o`, `pa_o` and `seg_o` are zero. These three outputs change only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Request strobe; taken only when idle |
| base_sel_i | input | 2 | Base register: 0 none, 1 BX, 2 BP, 3 not allowed |
| idx_sel_i | input | 2 | Index register: 0 none, 1 SI, 2 DI, 3 not allowed |
| disp_en_i | input | 1 | Displacement term present |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| disp_i | input | 16 | Displacement value |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| es_i | input | 16 | ES value |
| cs_i | input | 16 | CS value |
| ss_i | input | 16 | SS value |
| ds_i | input | 16 | DS value |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_sel_i | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| ea_o | output | 16 | Effective address |
| seg_o | output | 2 | Segment code used |
| pa_o | output | 20 | Physical address |
| illegal_o | output | 1 | Illegal-mode pulse |
| valid_o | output | 1 | Result-valid pulse |

## Verification
A legal result is due N cycles after the request cycle, where N is the number of terms the bench itself counts in the mode. A rejection is due exactly one cycle after the request cycle. The bench drives inputs and samples outputs on the falling clock edge. It confirms that `valid_o` is low on each falling edge before the due one and high on the due one. On the edge after that, it checks that the pulse has ended before it starts the next request. During the cycles in flight, the bench scrambles every operand input and pokes `req_i`, so that the result on the due edge shows whether sampling and busy-ignore behaved correctly.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  localparam int unsigned OFS_W     = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned PHYS_W    = OFS_W + SEG_SHIFT;
  localparam int unsigned MAX_TERMS = 3;
  localparam int unsigned TCNT_W    = $clog2(MAX_TERMS + 1);
  localparam int unsigned SHORT_W   = 8;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_code_e;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_BX   = 2'd1,
    BASE_BP   = 2'd2,
    BASE_BAD  = 2'd3
  } base_sel_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_SI   = 2'd1,
    IDX_DI   = 2'd2,
    IDX_BAD  = 2'd3
  } idx_sel_e;
endpackage

// File: rtl/seg_mode_decode.sv
// Mode decode: legality, term count, BP usage and the packed list of terms
// (present terms first, in base, index, displacement order).
module seg_mode_decode
  import seg_ea_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SW = SHORT_W,
  parameter int unsigned CW = TCNT_W
) (
  input  logic [1:0]                  base_sel,
  input  logic [1:0]                  idx_sel,
  input  logic                        disp_en,
  input  logic                        disp_wide,
  input  logic [OW-1:0]               disp,
  input  logic [OW-1:0]               bx,
  input  logic [OW-1:0]               bp,
  input  logic [OW-1:0]               si,
  input  logic [OW-1:0]               di,
  output logic                        legal,
  output logic                        uses_bp,
  output logic [CW-1:0]               term_cnt,
  output logic [MAX_TERMS-1:0][OW-1:0] terms
);
  base_sel_e base_e;
  idx_sel_e  idx_e;
  logic [OW-1:0] base_val;
  logic [OW-1:0] idx_val;
  logic [OW-1:0] disp_val;
  logic          disp_only;
  logic [MAX_TERMS-1:0]          present;
  logic [MAX_TERMS-1:0][OW-1:0]  raw;

  assign base_e = base_sel_e'(base_sel);
  assign idx_e  = idx_sel_e'(idx_sel);

  always_comb begin
    unique case (base_e)
      BASE_BX: base_val = bx;
      BASE_BP: base_val = bp;
      default: base_val = '0;
    endcase
  end

  always_comb begin
    unique case (idx_e)
      IDX_SI:  idx_val = si;
      IDX_DI:  idx_val = di;
      default: idx_val = '0;
    endcase
  end

  // A lone displacement is a full unsigned offset; otherwise a short one is sign-extended
  assign disp_only = disp_en && (base_e == BASE_NONE) && (idx_e == IDX_NONE);
  assign disp_val  = (disp_only || disp_wide) ? disp
                   : {{(OW-SW){disp[SW-1]}}, disp[SW-1:0]};

  assign present[0] = (base_e == BASE_BX) || (base_e == BASE_BP);
  assign present[1] = (idx_e == IDX_SI) || (idx_e == IDX_DI);
  assign present[2] = disp_en;
  assign raw[0]     = base_val;
  assign raw[1]     = idx_val;
  assign raw[2]     = disp_val;

  always_comb begin
    logic [CW-1:0] slot;
    terms = '0;
    slot  = '0;
    for (int i = 0; i < MAX_TERMS; i++) begin
      if (present[i]) begin
        terms[slot] = raw[i];
        slot        = slot + CW'(1);
      end
    end
    term_cnt = slot;
  end

  assign legal   = (base_e != BASE_BAD) && (idx_e != IDX_BAD) && (|present);
  assign uses_bp = (base_e == BASE_BP);
endmodule

// File: rtl/seg_select.sv
// Segment choice: override first, else stack segment for BP modes, else data segment.
module seg_select
  import seg_ea_pkg::*;
#(
  parameter int unsigned OW = OFS_W
) (
  input  logic          ovr_en,
  input  logic [1:0]    ovr_sel,
  input  logic          uses_bp,
  input  logic [OW-1:0] es,
  input  logic [OW-1:0] cs,
  input  logic [OW-1:0] ss,
  input  logic [OW-1:0] ds,
  output seg_code_e     seg_code,
  output logic [OW-1:0] seg_val
);
  logic [3:0][OW-1:0] bank;

  assign bank = {ds, ss, cs, es};

  always_comb begin
    if (ovr_en)       seg_code = seg_code_e'(ovr_sel);
    else if (uses_bp) seg_code = SEG_SS;
    else              seg_code = SEG_DS;
  end

  assign seg_val = bank[seg_code];
endmodule

// File: rtl/seg_ea_accum.sv
// Multi-cycle accumulation: one term per cycle, result registers updated on completion.
module seg_ea_accum
  import seg_ea_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SH = SEG_SHIFT,
  parameter int unsigned CW = TCNT_W,
  parameter int unsigned PW = OW + SH
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         reject,
  input  logic [MAX_TERMS-1:0][OW-1:0] terms,
  input  logic [CW-1:0]                term_cnt,
  input  seg_code_e                    seg_code,
  input  logic [OW-1:0]                seg_val,
  output logic                         busy,
  output logic [OW-1:0]                ea,
  output logic [1:0]                   seg,
  output logic [PW-1:0]                pa,
  output logic                         valid,
  output logic                         illegal
);
  localparam int unsigned RN = MAX_TERMS - 1;

  logic                   busy_q, busy_d;
  logic [CW-1:0]          left_q, left_d;
  logic [OW-1:0]          acc_q, acc_d;
  logic [RN-1:0][OW-1:0]  rem_q, rem_d;
  logic [OW-1:0]          segv_q;
  seg_code_e              segc_q;
  logic                   hold_en;
  logic                   acc_en;

  logic                   fin;
  logic [OW-1:0]          fin_ea;
  logic [OW-1:0]          fin_segv;
  seg_code_e              fin_segc;
  logic [PW-1:0]          fin_pa;
  logic [OW-1:0]          sum;

  logic [OW-1:0]          ea_q;
  logic [PW-1:0]          pa_q;
  seg_code_e              segc_out_q;
  logic                   valid_q, illeg_q;

  // next-state
  always_comb begin
    busy_d   = busy_q;
    left_d   = left_q;
    acc_d    = acc_q;
    rem_d    = rem_q;
    hold_en  = 1'b0;
    fin      = 1'b0;
    fin_ea   = acc_q;
    fin_segv = segv_q;
    fin_segc = segc_q;
    sum      = acc_q + rem_q[0];
    if (start) begin
      if (term_cnt == CW'(1)) begin
        fin      = 1'b1;
        fin_ea   = terms[0];
        fin_segv = seg_val;
        fin_segc = seg_code;
      end else begin
        hold_en = 1'b1;
        busy_d  = 1'b1;
        acc_d   = terms[0];
        for (int i = 0; i < RN; i++) rem_d[i] = terms[i+1];
        left_d  = term_cnt - CW'(1);
      end
    end else if (busy_q) begin
      if (left_q == CW'(1)) begin
        fin    = 1'b1;
        fin_ea = sum;
        busy_d = 1'b0;
        left_d = '0;
      end else begin
        acc_d = sum;
        for (int i = 0; i < RN - 1; i++) rem_d[i] = rem_q[i+1];
        rem_d[RN-1] = '0;
        left_d = left_q - CW'(1);
      end
    end
    fin_pa = {fin_segv, {SH{1'b0}}} + PW'(fin_ea);
  end

  assign acc_en = start || busy_q;

  // control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      left_q     <= '0;
      valid_q    <= 1'b0;
      illeg_q    <= 1'b0;
      ea_q       <= '0;
      pa_q       <= '0;
      segc_out_q <= SEG_ES;
    end else begin
      busy_q  <= busy_d;
      left_q  <= left_d;
      valid_q <= fin;
      illeg_q <= reject;
      if (fin) begin
        ea_q       <= fin_ea;
        pa_q       <= fin_pa;
        segc_out_q <= fin_segc;
      end
    end
  end

  // operand holding registers (datapath, no reset)
  always_ff @(posedge clk) begin
    if (acc_en) begin
      acc_q <= acc_d;
      rem_q <= rem_d;
    end
    if (hold_en) begin
      segv_q <= seg_val;
      segc_q <= seg_code;
    end
  end

  assign busy    = busy_q;
  assign ea      = ea_q;
  assign pa      = pa_q;
  assign seg     = segc_out_q;
  assign valid   = valid_q;
  assign illegal = illeg_q;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SH = SEG_SHIFT,
  parameter int unsigned PW = OW + SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [1:0]    base_sel_i,
  input  logic [1:0]    idx_sel_i,
  input  logic          disp_en_i,
  input  logic          disp_wide_i,
  input  logic [OW-1:0] disp_i,
  input  logic [OW-1:0] bx_i,
  input  logic [OW-1:0] bp_i,
  input  logic [OW-1:0] si_i,
  input  logic [OW-1:0] di_i,
  input  logic [OW-1:0] es_i,
  input  logic [OW-1:0] cs_i,
  input  logic [OW-1:0] ss_i,
  input  logic [OW-1:0] ds_i,
  input  logic          ovr_en_i,
  input  logic [1:0]    ovr_sel_i,
  output logic [OW-1:0] ea_o,
  output logic [1:0]    seg_o,
  output logic [PW-1:0] pa_o,
  output logic          illegal_o,
  output logic          valid_o
);
  logic                          legal_w;
  logic                          uses_bp_w;
  logic [TCNT_W-1:0]             cnt_w;
  logic [MAX_TERMS-1:0][OW-1:0]  terms_w;
  seg_code_e                     segc_w;
  logic [OW-1:0]                 segv_w;
  logic                          busy_w;
  logic                          take_w;
  logic                          start_w;
  logic                          reject_w;

  assign take_w   = req_i && !busy_w;
  assign start_w  = take_w && legal_w;
  assign reject_w = take_w && !legal_w;

  seg_mode_decode #(.OW(OW), .SW(SHORT_W), .CW(TCNT_W)) u_dec (
    .base_sel  (base_sel_i),
    .idx_sel   (idx_sel_i),
    .disp_en   (disp_en_i),
    .disp_wide (disp_wide_i),
    .disp      (disp_i),
    .bx        (bx_i),
    .bp        (bp_i),
    .si        (si_i),
    .di        (di_i),
    .legal     (legal_w),
    .uses_bp   (uses_bp_w),
    .term_cnt  (cnt_w),
    .terms     (terms_w)
  );

  seg_select #(.OW(OW)) u_seg (
    .ovr_en   (ovr_en_i),
    .ovr_sel  (ovr_sel_i),
    .uses_bp  (uses_bp_w),
    .es       (es_i),
    .cs       (cs_i),
    .ss       (ss_i),
    .ds       (ds_i),
    .seg_code (segc_w),
    .seg_val  (segv_w)
  );

  seg_ea_accum #(.OW(OW), .SH(SH), .CW(TCNT_W), .PW(PW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .reject   (reject_w),
    .terms    (terms_w),
    .term_cnt (cnt_w),
    .seg_code (segc_w),
    .seg_val  (segv_w),
    .busy     (busy_w),
    .ea       (ea_o),
    .seg      (seg_o),
    .pa       (pa_o),
    .valid    (valid_o),
    .illegal  (illegal_o)
  );
endmodule

// File: rtl/seg_ea_gen_chk.sv
module seg_ea_gen_chk
  import seg_ea_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SH = SEG_SHIFT,
  parameter int unsigned PW = OW + SH
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          busy,
  input logic          valid_o,
  input logic          illegal_o,
  input logic [OW-1:0] ea_o,
  input logic [1:0]    seg_o,
  input logic [PW-1:0] pa_o
);
  logic [TCNT_W-1:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + TCNT_W'(1);
    else           busy_run_q <= '0;
  end

  // R2: a rejection never coincides with a result
  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !valid_o);

  // R2: the illegal pulse follows a request cycle
  assert_illegal_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(req_i));

  // R11: a rejection only comes from a request taken while idle
  assert_idle_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !$past(busy));

  // R9: the segment adds only above the low SH bits
  assert_pa_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pa_o[SH-1:0] == ea_o[SH-1:0]));

  // R12: outputs hold between results
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(ea_o) && $stable(pa_o) && $stable(seg_o)));

  // R8: a calculation stays busy for at most MAX_TERMS-1 cycles
  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= TCNT_W'(MAX_TERMS - 1));
endmodule

bind seg_ea_gen seg_ea_gen_chk #(.OW(OW), .SH(SH), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .busy      (busy_w),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .ea_o      (ea_o),
  .seg_o     (seg_o),
  .pa_o      (pa_o)
);

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  base_sel_i = '0;
  logic [1:0]  idx_sel_i = '0;
  logic        disp_en_i = 1'b0;
  logic        disp_wide_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic [15:0] es_i = '0, cs_i = '0, ss_i = '0, ds_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [1:0]  ovr_sel_i = '0;
  logic [15:0] ea_o;
  logic [1:0]  seg_o;
  logic [19:0] pa_o;
  logic        illegal_o, valid_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [31:0] rng = 32'h1D2C_3B4A;
  logic [15:0] last_ea = '0;
  logic [19:0] last_pa = '0;
  logic [1:0]  last_seg = '0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  seg_ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i),
    .disp_en_i(disp_en_i), .disp_wide_i(disp_wide_i), .disp_i(disp_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
    .es_i(es_i), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i),
    .ovr_en_i(ovr_en_i), .ovr_sel_i(ovr_sel_i),
    .ea_o(ea_o), .seg_o(seg_o), .pa_o(pa_o),
    .illegal_o(illegal_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic rnd(output logic [15:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    v = rng[15:0];
  endtask

  task automatic fill_regs();
    rnd(bx_i); rnd(bp_i); rnd(si_i); rnd(di_i);
    rnd(es_i); rnd(cs_i); rnd(ss_i); rnd(ds_i); rnd(disp_i);
  endtask

  // Issue one request with the current inputs and check it; scramble/poke inputs in flight.
  task automatic fire(input string ea_tag, input bit scramble);
    logic        lg;
    int          n;
    logic [15:0] bv, iv, dv, eaexp, sv;
    logic [1:0]  sc;
    logic [19:0] paexp;
    string       seg_tag;
    lg = (base_sel_i != 2'd3) && (idx_sel_i != 2'd3) &&
         ((base_sel_i != 2'd0) || (idx_sel_i != 2'd0) || disp_en_i);
    n = 0;
    if (base_sel_i == 2'd1 || base_sel_i == 2'd2) n++;
    if (idx_sel_i == 2'd1 || idx_sel_i == 2'd2) n++;
    if (disp_en_i) n++;
    bv = (base_sel_i == 2'd1) ? bx_i : (base_sel_i == 2'd2) ? bp_i : 16'h0;
    iv = (idx_sel_i == 2'd1) ? si_i : (idx_sel_i == 2'd2) ? di_i : 16'h0;
    if (base_sel_i == 2'd0 && idx_sel_i == 2'd0) dv = disp_i;
    else if (disp_wide_i)                        dv = disp_i;
    else                                         dv = {{8{disp_i[7]}}, disp_i[7:0]};
    if (!disp_en_i) dv = 16'h0;
    eaexp = bv + iv + dv;
    sc = ovr_en_i ? ovr_sel_i : ((base_sel_i == 2'd2) ? 2'd2 : 2'd3);
    seg_tag = ovr_en_i ? "R4" : "R3";
    case (sc)
      2'd0:    sv = es_i;
      2'd1:    sv = cs_i;
      2'd2:    sv = ss_i;
      default: sv = ds_i;
    endcase
    paexp = {sv, 4'h0} + {4'h0, eaexp};

    // previous pulse has ended and no stray result came from an ignored request
    chk(!valid_o && !illegal_o, "R8,R11", "idle before request",
        {30'h0, valid_o, illegal_o}, 32'h0);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    if (scramble) begin
      fill_regs();
      base_sel_i = ~base_sel_i; idx_sel_i = idx_sel_i + 2'd1;
      disp_en_i = ~disp_en_i; disp_wide_i = ~disp_wide_i;
      ovr_en_i = ~ovr_en_i; ovr_sel_i = ~ovr_sel_i;
    end
    if (!lg) begin
      chk(illegal_o == 1'b1, "R2", "illegal flag", {31'h0, illegal_o}, 32'h1);
      chk(valid_o == 1'b0, "R2", "no result for illegal", {31'h0, valid_o}, 32'h0);
      chk(ea_o == last_ea && pa_o == last_pa && seg_o == last_seg, "R12",
          "outputs held on reject", {12'h0, pa_o}, {12'h0, last_pa});
    end else begin
      for (int c = 1; c < n; c++) begin
        chk(valid_o == 1'b0 && illegal_o == 1'b0, "R8", "early pulse",
            {30'h0, valid_o, illegal_o}, 32'h0);
        if (c == 1 && scramble) req_i = 1'b1; // R11: request while busy
        @(negedge clk);
        req_i = 1'b0;
      end
      chk(valid_o == 1'b1, "R8", "valid at due cycle", {31'h0, valid_o}, 32'h1);
      chk(ea_o == eaexp, ea_tag, "effective address", {16'h0, ea_o}, {16'h0, eaexp});
      chk(seg_o == sc, seg_tag, "segment code", {30'h0, seg_o}, {30'h0, sc});
      chk(pa_o == paexp, "R9", "physical address", {12'h0, pa_o}, {12'h0, paexp});
      last_ea = eaexp; last_pa = paexp; last_seg = sc;
    end
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] b, input logic [1:0] x, input logic de,
                          input logic wd, input logic oe, input logic [1:0] os);
    base_sel_i = b; idx_sel_i = x; disp_en_i = de; disp_wide_i = wd;
    ovr_en_i = oe; ovr_sel_i = os;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!valid_o && !illegal_o, "R12", "flags after reset", {30'h0, valid_o, illegal_o}, 32'h0);
    chk(ea_o == 16'h0 && pa_o == 20'h0 && seg_o == 2'd0, "R12", "outputs after reset",
        {12'h0, pa_o}, 32'h0);

    // reference vectors (R1, R3)
    fill_regs();
    set_mode(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0);
    bx_i = 16'h1000; si_i = 16'h0880; ds_i = 16'h0000;
    fire("R1", 1'b0);
    chk(ea_o == 16'h1880, "R1", "vector BX+SI", {16'h0, ea_o}, 32'h1880);
    set_mode(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0);
    bp_i = 16'h1598; di_i = 16'h1004;
    fire("R1", 1'b0);
    chk(ea_o == 16'h259C && seg_o == 2'd2, "R3", "vector BP+DI", {16'h0, ea_o}, 32'h259C);
    set_mode(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0);
    bp_i = 16'h1000; di_i = 16'h0005; disp_i = 16'h0125;
    fire("R1", 1'b0);
    chk(ea_o == 16'h112A, "R1", "vector BP+DI+disp", {16'h0, ea_o}, 32'h112A);
    set_mode(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0);
    bx_i = 16'h2000; si_i = 16'h0120; disp_i = 16'h0010;
    fire("R1", 1'b0);
    chk(ea_o == 16'h2130 && seg_o == 2'd3, "R3", "vector BX+SI+disp", {16'h0, ea_o}, 32'h2130);

    // R7: wrap of the offset sum
    set_mode(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0);
    bx_i = 16'h0010; disp_i = 16'hFFFF;
    fire("R7", 1'b0);
    chk(ea_o == 16'h000F, "R7", "offset wrap", {16'h0, ea_o}, 32'h000F);

    // R6: short displacement, junk upper byte, negative
    set_mode(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0);
    bx_i = 16'h0100; disp_i = 16'hAB80;
    fire("R6", 1'b0);
    chk(ea_o == 16'h0080, "R6", "short disp sign-extended", {16'h0, ea_o}, 32'h0080);

    // R5: displacement-only ignores width flag; R9: physical wrap
    set_mode(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0);
    disp_i = 16'h0020; ds_i = 16'hFFFF;
    fire("R5", 1'b0);
    chk(pa_o == 20'h00010, "R9", "physical wrap", {12'h0, pa_o}, 32'h00010);
    disp_i = 16'hFF80;
    fire("R5", 1'b0);
    chk(ea_o == 16'hFF80, "R5", "full unsigned disp-only", {16'h0, ea_o}, 32'hFF80);

    // R2: no-term request
    set_mode(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    fire("R2", 1'b0);

    // near-exhaustive sweep: every mode code, override choice and width, inputs scrambled in flight (R10)
    for (int b = 0; b < 4; b++)
      for (int x = 0; x < 4; x++)
        for (int de = 0; de < 2; de++)
          for (int ov = 0; ov < 5; ov++)
            for (int wd = 0; wd < 2; wd++) begin
              fill_regs();
              set_mode(2'(b), 2'(x), 1'(de), 1'(wd), (ov < 4), 2'(ov));
              fire("R1,R10", 1'b1);
            end

    chk(!valid_o && !illegal_o, "R11", "quiet at end", {30'h0, valid_o, illegal_o}, 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule